// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pair Checker

Each cycle this block looks at one 64-bit fetch packet and decides how many of its two instructions leave issue: none, one, or both. The left half carries an integer-side instruction (ALU op, integer load, FP load) or an FP operation. The right half always carries an FP operation. Issue stays in order. The right instruction may only go in the same cycle as the left one, or after the left one has already gone. Whatever does not issue is held, and `stall` tells fetch to present the same packet again on the next cycle.

The block reads decoded register specifiers for both slots and a scoreboard bit-vector of destinations still owed by loads in flight. It also keeps a one-cycle record of the load it just issued. A load result therefore cannot be consumed by the right slot of its own packet, or by either slot of the following issue cycle. Together these cover the three instruction slots that a one-cycle load delay spans on a paired pipeline.

Top module: `pair_issue_gate`

## Requirements
- R1: While reset is asserted, and for two rising edges after it is released, neither slot issues. During that time `stall` equals `pkt_vld && (l_vld || r_vld)`.
- R2: The right slot issues only if one of three holds: the left slot issues in the same cycle, the left slot already issued from this packet, or `l_vld` is 0.
- R3: At most two instructions issue per cycle. `stall` is high exactly when `pkt_vld` is high and some valid slot of the packet has still not issued.
- R4: A slot is blocked if either of its source specifiers, or its destination specifier, is non-zero and has its bit set in `pend_mask`. Bit i of `pend_mask` corresponds to specifier value i.
- R5: If the left slot is still unissued at the start of the cycle and has a non-zero destination, the right slot cannot issue when its destination or either source equals that destination.
- R6: When a load (`l_kind`=1) issues in cycle t, any source in cycle t+1 that equals its non-zero destination blocks that slot. This applies to both slots.
- R7: A left FP operation (`l_kind`=2) never issues together with the right FP operation. The right one is offered alone in a later cycle.
- R8: An FP load in the left slot paired with an independent right FP operation issues both in one cycle.
- R9: Once only the left slot has issued, the packet is held (`stall`=1). The left slot does not issue again, and only the right slot is checked until it issues.
- R10: Specifier 0 (integer register 0) never causes a hazard, whether from `pend_mask` or from the load record.
- R11: With `pkt_vld` low, nothing issues and `stall` is low.
- Encoding: a specifier is {bank, index}, with bank 1 for FP registers. `l_kind` is 0 for an ALU op, 1 for a load, 2 for an FP op, and 3 for another integer op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_vld | input | 1 | A fetch packet is presented |
| l_vld | input | 1 | Left slot holds an instruction |
| l_kind | input | 2 | Left slot class (0 ALU, 1 load, 2 FP op, 3 other int) |
| l_dst | input | IDX_W+1 | Left destination specifier |
| l_src_a | input | IDX_W+1 | Left first source specifier |
| l_src_b | input | IDX_W+1 | Left second source specifier |
| r_vld | input | 1 | Right slot holds an FP operation |
| r_dst | input | IDX_W+1 | Right destination specifier |
| r_src_a | input | IDX_W+1 | Right first source specifier |
| r_src_b | input | IDX_W+1 | Right second source specifier |
| pend_mask | input | 2^(IDX_W+1) | Destinations owed by in-flight loads |
| issue_l | output | 1 | Left slot issues this cycle |
| issue_r | output | 1 | Right slot issues this cycle |
| stall | output | 1 | Hold this packet for another cycle |

## Verification
`issue_l`, `issue_r` and `stall` are combinational in the current packet, `pend_mask` and two state bits, so each is due in the same cycle the packet is driven. The bench drives on the falling edge and samples 2 ns later, before the next rising edge. The load record and the left-issued flag change only at the rising edge, so load-shadow (R6) and held-right (R9) effects are checked one and two cycles after the stimulus, on the held packet. Reset release takes two edges through the synchronizer, and the bench waits out that delay before expecting issue.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;
  typedef enum logic [1:0] {
    K_ALU  = 2'd0,
    K_LOAD = 2'd1,
    K_FPOP = 2'd2,
    K_INT  = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/iss_rst_sync.sv
module iss_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/iss_load_shadow.sv
module iss_load_shadow #(
  parameter int SPEC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_issue,
  input  logic [SPEC_W-1:0] ld_dst,
  output logic              shadow_v,
  output logic [SPEC_W-1:0] shadow_spec
);
  logic              v_n;
  logic [SPEC_W-1:0] spec_n;
  logic              spec_en;

  always_comb begin
    v_n     = ld_issue;
    spec_en = ld_issue;
    spec_n  = ld_dst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_v <= 1'b0;
    else        shadow_v <= v_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_spec <= '0;
    else if (spec_en) shadow_spec <= spec_n;
  end
endmodule

// File: rtl/iss_operand_chk.sv
module iss_operand_chk #(
  parameter int SPEC_W = 6,
  parameter int NSPEC  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SPEC_W-1:0] src_a,
  input  logic [SPEC_W-1:0] src_b,
  input  logic [SPEC_W-1:0] dst,
  input  logic [NSPEC-1:0]  pend_mask,
  input  logic              shadow_v,
  input  logic [SPEC_W-1:0] shadow_spec,
  output logic              clear
);
  logic a_hit, b_hit, d_hit;

  always_comb begin
    a_hit = (src_a != '0) && (pend_mask[src_a] || (shadow_v && shadow_spec == src_a));
    b_hit = (src_b != '0) && (pend_mask[src_b] || (shadow_v && shadow_spec == src_b));
    d_hit = (dst   != '0) && pend_mask[dst];
    clear = !(a_hit || b_hit || d_hit);
  end

  assert_zero_spec_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == '0 && src_b == '0 && dst == '0) |-> clear);

  assert_pending_src_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a != '0 && pend_mask[src_a]) |-> !clear);
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate #(
  parameter int IDX_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pkt_vld,
  input  logic                          l_vld,
  input  logic [1:0]                    l_kind,
  input  logic [IDX_W:0]                l_dst,
  input  logic [IDX_W:0]                l_src_a,
  input  logic [IDX_W:0]                l_src_b,
  input  logic                          r_vld,
  input  logic [IDX_W:0]                r_dst,
  input  logic [IDX_W:0]                r_src_a,
  input  logic [IDX_W:0]                r_src_b,
  input  logic [(1 << (IDX_W+1))-1:0]   pend_mask,
  output logic                          issue_l,
  output logic                          issue_r,
  output logic                          stall
);
  import pair_issue_pkg::*;

  localparam int SPEC_W = IDX_W + 1;
  localparam int NSPEC  = 1 << SPEC_W;
  localparam int NSLOT  = 2;

  logic              run;
  logic              left_done_q, left_done_n;
  logic              shadow_v;
  logic [SPEC_W-1:0] shadow_spec;
  slot_kind_e        lk;
  logic [SPEC_W-1:0] s_a [NSLOT];
  logic [SPEC_W-1:0] s_b [NSLOT];
  logic [SPEC_W-1:0] s_d [NSLOT];
  logic [NSLOT-1:0]  slot_ok;
  logic              left_pend, left_clear, same_dep, fp_clash, pkt_done;

  iss_rst_sync u_sync (.clk(clk), .arst_n(rst_n), .rst_q(run));

  assign lk = slot_kind_e'(l_kind);

  always_comb begin
    s_a[0] = l_src_a; s_b[0] = l_src_b; s_d[0] = l_dst;
    s_a[1] = r_src_a; s_b[1] = r_src_b; s_d[1] = r_dst;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    iss_operand_chk #(.SPEC_W(SPEC_W), .NSPEC(NSPEC)) u_chk (
      .clk(clk), .rst_n(run),
      .src_a(s_a[s]), .src_b(s_b[s]), .dst(s_d[s]),
      .pend_mask(pend_mask),
      .shadow_v(shadow_v), .shadow_spec(shadow_spec),
      .clear(slot_ok[s])
    );
  end

  iss_load_shadow #(.SPEC_W(SPEC_W)) u_shadow (
    .clk(clk), .rst_n(run),
    .ld_issue(issue_l && lk == K_LOAD),
    .ld_dst(l_dst),
    .shadow_v(shadow_v), .shadow_spec(shadow_spec)
  );

  always_comb begin
    left_pend  = run && pkt_vld && l_vld && !left_done_q;
    issue_l    = left_pend && slot_ok[0];
    left_clear = !l_vld || left_done_q || issue_l;
    same_dep   = left_pend && (l_dst != '0) &&
                 (r_src_a == l_dst || r_src_b == l_dst || r_dst == l_dst);
    fp_clash   = left_pend && (lk == K_FPOP);
    issue_r    = run && pkt_vld && r_vld && left_clear && !same_dep &&
                 !fp_clash && slot_ok[1];
    pkt_done   = left_clear && (!r_vld || issue_r);
    stall      = pkt_vld && !pkt_done;
  end

  always_comb begin
    left_done_n = left_done_q;
    if (pkt_vld) left_done_n = stall ? (left_done_q || issue_l) : 1'b0;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) left_done_q <= 1'b0;
    else      left_done_q <= left_done_n;
  end

  assert_right_pairs_left_R2: assert property (@(posedge clk) disable iff (!run)
    issue_r |-> (issue_l || left_done_q || !l_vld));

  assert_left_once_R9: assert property (@(posedge clk) disable iff (!run)
    left_done_q |-> !issue_l);

  assert_fp_pair_split_R7: assert property (@(posedge clk) disable iff (!run)
    (issue_l && lk == K_FPOP) |-> !issue_r);

  assert_load_shadow_R6: assert property (@(posedge clk) disable iff (!run)
    ($past(run) && $past(issue_l && lk == K_LOAD) && $past(l_dst) != '0 && issue_l)
      |-> (l_src_a != $past(l_dst) && l_src_b != $past(l_dst)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!run)
    !pkt_vld |-> (!issue_l && !issue_r && !stall));
endmodule

// File: tb/sim_pair_issue_gate.sv
module sim_pair_issue_gate;
  localparam int IDX_W = 2;
  localparam int SW    = IDX_W + 1;
  localparam int NS    = 1 << SW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pkt_vld, l_vld, r_vld;
  logic [1:0] l_kind;
  logic [SW-1:0] l_dst, l_src_a, l_src_b, r_dst, r_src_a, r_src_b;
  logic [NS-1:0] pend_mask;
  logic issue_l, issue_r, stall;

  int total = 0;
  int bad = 0;
  bit m_run, m_ldone, m_ldv, m_st;
  logic [SW-1:0] m_lds;

  pair_issue_gate #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_vld(pkt_vld), .l_vld(l_vld), .l_kind(l_kind),
    .l_dst(l_dst), .l_src_a(l_src_a), .l_src_b(l_src_b), .r_vld(r_vld),
    .r_dst(r_dst), .r_src_a(r_src_a), .r_src_b(r_src_b), .pend_mask(pend_mask),
    .issue_l(issue_l), .issue_r(issue_r), .stall(stall)
  );

  task automatic chk1(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic bit hz_src(input logic [SW-1:0] s);
    return (s != 0) && (pend_mask[s] || (m_ldv && m_lds == s));
  endfunction

  function automatic bit hz_dst(input logic [SW-1:0] s);
    return (s != 0) && pend_mask[s];
  endfunction

  task automatic set_pkt(input bit pv, input bit lv, input logic [1:0] lk,
                         input int ld, input int la, input int lb,
                         input bit rv, input int rd, input int ra, input int rb);
    pkt_vld = pv; l_vld = lv; l_kind = lk;
    l_dst = SW'(ld); l_src_a = SW'(la); l_src_b = SW'(lb);
    r_vld = rv; r_dst = SW'(rd); r_src_a = SW'(ra); r_src_b = SW'(rb);
  endtask

  // Inputs are set after a falling edge; sample 2 ns later, then advance model.
  task automatic step(input bit use_exp, input bit el, input bit er, input bit es,
                      input string tag);
    bit lp, il, lclr, same, fpc, ir, st;
    lp   = m_run && pkt_vld && l_vld && !m_ldone;
    il   = lp && !hz_src(l_src_a) && !hz_src(l_src_b) && !hz_dst(l_dst);
    lclr = !l_vld || m_ldone || il;
    same = lp && l_dst != 0 && (r_src_a == l_dst || r_src_b == l_dst || r_dst == l_dst);
    fpc  = lp && l_kind == 2'd2;
    ir   = m_run && pkt_vld && r_vld && lclr && !same && !fpc &&
           !hz_src(r_src_a) && !hz_src(r_src_b) && !hz_dst(r_dst);
    st   = pkt_vld && !(lclr && (!r_vld || ir));
    #2;
    if (use_exp) begin
      chk1(tag, "issue_l", issue_l, el);
      chk1(tag, "issue_r", issue_r, er);
      chk1(tag, "stall", stall, es);
    end else begin
      chk1(tag, "issue_l", issue_l, il);
      chk1(tag, "issue_r", issue_r, ir);
      chk1(tag, "stall", stall, st);
    end
    if (!m_run) begin
      m_ldone = 0; m_ldv = 0;
    end else begin
      m_ldv = il && l_kind == 2'd1;
      if (m_ldv) m_lds = l_dst;
      if (pkt_vld) m_ldone = st ? (m_ldone | il) : 1'b0;
    end
    m_st = st;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_run = 0; m_ldone = 0; m_ldv = 0; m_lds = '0; m_st = 0;
    rst_n = 1'b0; pend_mask = '0;
    set_pkt(0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    step(1, 0, 0, 0, "R1 reset idle");
    set_pkt(1, 1, 2'd0, 1, 2, 3, 1, 6, 7, 4);
    step(1, 0, 0, 1, "R1 reset held");
    rst_n = 1'b1;
    set_pkt(0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, "R11 idle after release");
    step(1, 0, 0, 0, "R11 idle after release");
    step(1, 0, 0, 0, "R11 idle after release");
    m_run = 1;

    // FP load + independent FP op pair
    set_pkt(1, 1, 2'd1, 5, 1, 0, 1, 6, 7, 4);
    step(1, 1, 1, 0, "R8 fp load pair");
    // next packet reads f1 in left FP op; then FP-op pair splits
    set_pkt(1, 1, 2'd2, 4, 5, 7, 1, 6, 7, 7);
    step(1, 0, 0, 1, "R6 left in shadow");
    step(1, 1, 0, 1, "R7 fp op pair split");
    step(1, 0, 1, 0, "R9 right alone");

    set_pkt(1, 1, 2'd1, 6, 1, 2, 1, 7, 5, 4);
    step(1, 1, 1, 0, "R8 second pair");
    set_pkt(1, 1, 2'd0, 1, 2, 3, 1, 7, 6, 4);
    step(1, 1, 0, 1, "R6 right in shadow");
    step(1, 0, 1, 0, "R9 right after hold");

    set_pkt(1, 1, 2'd1, 5, 2, 0, 1, 7, 5, 4);
    step(1, 1, 0, 1, "R5 same packet use");
    step(1, 0, 0, 1, "R6 third slot blocked");
    step(1, 0, 1, 0, "R9 right finally");

    pend_mask = 8'b0000_1000;
    set_pkt(1, 1, 2'd0, 1, 3, 2, 1, 6, 7, 4);
    step(1, 0, 0, 1, "R4 left src pending and R2 right waits");
    pend_mask = '0;
    step(1, 1, 1, 0, "R4 released");
    pend_mask = 8'b1000_0000;
    set_pkt(1, 1, 2'd0, 2, 1, 1, 1, 7, 5, 4);
    step(1, 1, 0, 1, "R4 right dest pending");
    pend_mask = '0;
    step(1, 0, 1, 0, "R4 right dest cleared");
    pend_mask = 8'b0000_0010;
    set_pkt(1, 1, 2'd0, 1, 2, 3, 0, 0, 0, 0);
    step(1, 0, 0, 1, "R4 left dest pending");
    pend_mask = '0;
    step(1, 1, 0, 0, "R3 single left");

    pend_mask = 8'b0000_0001;
    set_pkt(1, 1, 2'd1, 0, 0, 0, 1, 4, 5, 6);
    step(1, 1, 1, 0, "R10 load to r0");
    set_pkt(1, 1, 2'd0, 0, 0, 0, 1, 5, 4, 6);
    step(1, 1, 1, 0, "R10 r0 sources");
    pend_mask = '0;

    set_pkt(1, 0, 2'd0, 0, 0, 0, 1, 6, 5, 4);
    step(1, 0, 1, 0, "R2 empty left");
    set_pkt(0, 1, 2'd0, 1, 2, 3, 1, 6, 5, 4);
    step(1, 0, 0, 0, "R11 no packet");

    pend_mask = 8'b0100_0100;
    set_pkt(1, 1, 2'd0, 1, 2, 3, 1, 7, 6, 4);
    step(1, 0, 0, 1, "R3 zero issue");
    pend_mask = '0;
    step(1, 1, 1, 0, "R3 two issue");

    for (int n = 0; n < 3000; n++) begin
      if (!m_st) begin
        set_pkt(($urandom % 10) != 0, ($urandom % 5) != 0, 2'($urandom),
                int'($urandom % NS), int'($urandom % NS), int'($urandom % NS),
                ($urandom % 5) != 0,
                int'($urandom % NS), int'($urandom % NS), int'($urandom % NS));
      end
      pend_mask = NS'($urandom & $urandom & $urandom);
      step(0, 0, 0, 0, "R3 sweep");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule